// File: doc/BRIEF.md
# Speculative Write-Back Gating Controller

This controller sits between instruction dispatch and the register write-back stage of a processor core. It keeps a small table of in-flight instructions, indexed by destination tag. For each one it decides when the result may be written back. The controller allows one predicted conditional branch to be outstanding at a time. Integer, memory and system-register instructions issued behind that branch are marked speculative. They may execute and report completion, but their write-back stays blocked until the branch resolves. A second branch-class instruction is not accepted while the first is still unresolved.

When the branch resolves as correctly predicted, every held write-back is released together in the next cycle, and issue carries on without a gap. When the branch resolves as mispredicted, the controller does three things in that same cycle:

- It raises a flush strobe with the first and last speculative tags and their number.
- It asks fetch to redirect.
- It drops every speculative entry so that none of them can ever write back.

Instructions issued before the branch are not affected by a misprediction.

Top module: `specwb_gate`

## Requirements
- R1: After reset, no write-back enable, flush or redirect is active, and issue is ready for every class.
- R2: A non-speculative instruction whose completion is reported in cycle t asserts its write-back enable bit (bit index = tag) in cycle t+1 only, and its slot is then free.
- R3: A speculative instruction's write-back enable stays low while its branch is unresolved, even after its completion has been reported.
- R4: While a branch is pending and no resolve is present, issue is not ready for class 3 (branch), and it stays ready for classes 0, 1 and 2 (integer, memory, system register).
- R5: A correct resolve in cycle t asserts the write-back enables of all completed speculative entries together in cycle t+1. Speculative entries that have not completed yet write back normally once they complete.
- R6: A mispredicted resolve raises the flush strobe and the redirect request in the same cycle. The flush range reports the first and last speculative tags in issue order and their count. The redirect direction equals the resolve's taken flag.
- R7: After a misprediction, a squashed tag never asserts write-back, even if its completion arrives later. Instructions issued before the branch still write back.
- R8: An issue in the same cycle as a resolve is non-speculative. A class 3 issue in that cycle is accepted and opens a new pending branch.
- R9: A resolve that arrives while no branch is pending is ignored: no flush, no redirect and no write-back.
- R10: A completion report for a tag that holds no instruction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Dispatch offers an instruction |
| issueClass | input | 2 | Unit class: 0 integer, 1 memory, 2 system register, 3 branch |
| issueTag | input | TAG_W | Destination tag (table slot) of the offered instruction |
| issueReady | output | 1 | Offer is accepted this cycle |
| doneValid | input | 1 | An execution unit reports that a result has reached write-back |
| doneTag | input | TAG_W | Tag of the completed result |
| resolveValid | input | 1 | Branch outcome is available |
| resolveTaken | input | 1 | Actual branch direction |
| resolveMispredict | input | 1 | Prediction was wrong |
| wbEn | output | 2**TAG_W | Per-tag write-back enable |
| flushValid | output | 1 | Squash the speculative range |
| flushFirst | output | TAG_W | First speculative tag in issue order |
| flushLast | output | TAG_W | Last speculative tag in issue order |
| flushCount | output | TAG_W+1 | Number of speculative tags squashed |
| redirectValid | output | 1 | Fetch must restart on the correct path |
| redirectTaken | output | 1 | Direction of the correct path |

## Verification
A wrong speculative bit in a slot shows up on `wbEn`. The bit either fires while a branch is pending, or it stays low in the cycle after a correct resolve. Either way the error is visible one cycle after the resolve or completion that exposes it. A wrong pending flag shows up on `issueReady` for class 3, or as a flush or redirect on a resolve that should have been ignored. Both are visible combinationally in that same cycle. Wrong range tracking shows up on `flushFirst`, `flushLast` and `flushCount` in the mispredict cycle. A slot that is not freed correctly shows up as a write-back that repeats, or one that never comes, in a later sweep step.

// File: rtl/specwb_pkg.sv
package specwb_pkg;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MEM = 2'd1,
    CLS_SYS = 2'd2,
    CLS_BR  = 2'd3
  } unitClassT;

  // strobes from control to the slot table
  typedef struct packed {
    logic alloc;      // an issue is accepted this cycle
    logic allocSpec;  // the accepted issue is speculative
    logic commitSpec; // pending branch resolved as predicted
    logic squash;     // pending branch resolved as mispredicted
  } gateStrobeT;

endpackage

// File: rtl/specwb_ctrl.sv
module specwb_ctrl
  import specwb_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [1:0]       issueClass,
  input  logic [TAG_W-1:0] issueTag,
  input  logic             resolveValid,
  input  logic             resolveTaken,
  input  logic             resolveMispredict,
  output logic             issueReady,
  output gateStrobeT       strb,
  output logic             flushValid,
  output logic [TAG_W-1:0] flushFirst,
  output logic [TAG_W-1:0] flushLast,
  output logic [TAG_W:0]   flushCount,
  output logic             redirectValid,
  output logic             redirectTaken
);

  localparam int SLOTS = 1 << TAG_W;

  logic             pending;
  logic [TAG_W-1:0] specFirst;
  logic [TAG_W-1:0] specLast;
  logic [TAG_W:0]   specCount;

  logic resolveNow;
  logic isBranch;
  logic accept;
  logic openBranch;

  always_comb begin
    resolveNow = resolveValid && pending;
    isBranch   = (issueClass == CLS_BR);
    // resolve applies before a same-cycle issue
    issueReady = !(isBranch && pending && !resolveNow);
    accept     = issueValid && issueReady;
    openBranch = accept && isBranch;

    strb.alloc      = accept;
    strb.allocSpec  = accept && pending && !resolveNow;
    strb.commitSpec = resolveNow && !resolveMispredict;
    strb.squash     = resolveNow && resolveMispredict;

    flushValid    = strb.squash;
    flushFirst    = specFirst;
    flushLast     = specLast;
    flushCount    = specCount;
    redirectValid = strb.squash;
    redirectTaken = resolveTaken;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      specFirst <= '0;
      specLast  <= '0;
      specCount <= '0;
    end else begin
      pending <= (pending && !resolveNow) || openBranch;
      if (resolveNow || openBranch) begin
        specCount <= '0;
      end else if (strb.allocSpec) begin
        if (specCount == '0) specFirst <= issueTag;
        specLast  <= issueTag;
        specCount <= specCount + 1'b1;
      end
    end
  end

  // R4: an offered branch with no resolve keeps the window open
  a_r4_branch_held: assert property (@(posedge clk) disable iff (!rstN)
    (pending && issueValid && isBranch && !resolveValid) |=> pending);

  // R5: any resolve of a pending branch empties the speculative range
  a_r5_range_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && pending) |=> (specCount == '0));

  // R6: the range never exceeds the table
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    specCount <= (TAG_W+1)'(SLOTS));

  // R9: a stray resolve leaves the idle state idle
  a_r9_stray_resolve: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && !pending && !(issueValid && isBranch)) |=> !pending);

endmodule

// File: rtl/specwb_slots.sv
module specwb_slots
  import specwb_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStrobeT       strb,
  input  logic [TAG_W-1:0] issueTag,
  input  logic             doneValid,
  input  logic [TAG_W-1:0] doneTag,
  output logic [(1<<TAG_W)-1:0] wbEn
);

  localparam int SLOTS = 1 << TAG_W;

  logic [SLOTS-1:0] slotValid;
  logic [SLOTS-1:0] slotSpec;
  logic [SLOTS-1:0] slotDone;

  for (genvar i = 0; i < SLOTS; i++) begin : gSlot
    logic hitAlloc;
    logic hitDone;

    always_comb begin
      hitAlloc = strb.alloc && (issueTag == TAG_W'(i));
      hitDone  = doneValid && (doneTag == TAG_W'(i)) && slotValid[i];
      wbEn[i]  = slotValid[i] && slotDone[i] && !slotSpec[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[i] <= 1'b0;
        slotSpec[i]  <= 1'b0;
        slotDone[i]  <= 1'b0;
      end else if (hitAlloc) begin
        slotValid[i] <= 1'b1;
        slotSpec[i]  <= strb.allocSpec;
        slotDone[i]  <= 1'b0;
      end else if (strb.squash && slotSpec[i]) begin
        slotValid[i] <= 1'b0;
        slotSpec[i]  <= 1'b0;
        slotDone[i]  <= 1'b0;
      end else if (wbEn[i]) begin
        slotValid[i] <= 1'b0;
        slotDone[i]  <= 1'b0;
      end else begin
        if (strb.commitSpec) slotSpec[i] <= 1'b0;
        if (hitDone) slotDone[i] <= 1'b1;
      end
    end

    // R2: one write-back per instruction
    a_r2_single_wb: assert property (@(posedge clk) disable iff (!rstN)
      wbEn[i] |=> !wbEn[i]);

    // R3: a completed speculative result stays held until resolve
    a_r3_held: assert property (@(posedge clk) disable iff (!rstN)
      (slotValid[i] && slotSpec[i] && slotDone[i] && !strb.commitSpec && !strb.squash)
        |=> (slotValid[i] && !wbEn[i]));

    // R7: a squashed slot is emptied
    a_r7_squashed: assert property (@(posedge clk) disable iff (!rstN)
      (strb.squash && slotSpec[i] && !hitAlloc) |=> !slotValid[i]);

    // R10: completion for an empty slot produces no write-back
    a_r10_empty_done: assert property (@(posedge clk) disable iff (!rstN)
      (doneValid && (doneTag == TAG_W'(i)) && !slotValid[i]) |=> !wbEn[i]);
  end

endmodule

// File: rtl/specwb_gate.sv
module specwb_gate
  import specwb_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issueValid,
  input  logic [1:0]            issueClass,
  input  logic [TAG_W-1:0]      issueTag,
  output logic                  issueReady,
  input  logic                  doneValid,
  input  logic [TAG_W-1:0]      doneTag,
  input  logic                  resolveValid,
  input  logic                  resolveTaken,
  input  logic                  resolveMispredict,
  output logic [(1<<TAG_W)-1:0] wbEn,
  output logic                  flushValid,
  output logic [TAG_W-1:0]      flushFirst,
  output logic [TAG_W-1:0]      flushLast,
  output logic [TAG_W:0]        flushCount,
  output logic                  redirectValid,
  output logic                  redirectTaken
);

  gateStrobeT strb;

  specwb_ctrl #(.TAG_W(TAG_W)) uCtrl (
    .clk               (clk),
    .rstN              (rstN),
    .issueValid        (issueValid),
    .issueClass        (issueClass),
    .issueTag          (issueTag),
    .resolveValid      (resolveValid),
    .resolveTaken      (resolveTaken),
    .resolveMispredict (resolveMispredict),
    .issueReady        (issueReady),
    .strb              (strb),
    .flushValid        (flushValid),
    .flushFirst        (flushFirst),
    .flushLast         (flushLast),
    .flushCount        (flushCount),
    .redirectValid     (redirectValid),
    .redirectTaken     (redirectTaken)
  );

  specwb_slots #(.TAG_W(TAG_W)) uSlots (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .issueTag  (issueTag),
    .doneValid (doneValid),
    .doneTag   (doneTag),
    .wbEn      (wbEn)
  );

  // R6: flush and redirect only ever appear together with a resolve
  a_r6_flush_needs_resolve: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> (resolveValid && resolveMispredict && redirectValid));

endmodule

// File: tb/tb_specwb_gate.sv
module tb_specwb_gate;
  localparam int TAG_W = 3;
  localparam int SLOTS = 1 << TAG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [1:0] issueClass = 2'd0;
  logic [TAG_W-1:0] issueTag = '0;
  logic issueReady;
  logic doneValid = 1'b0;
  logic [TAG_W-1:0] doneTag = '0;
  logic resolveValid = 1'b0;
  logic resolveTaken = 1'b0;
  logic resolveMispredict = 1'b0;
  logic [SLOTS-1:0] wbEn;
  logic flushValid;
  logic [TAG_W-1:0] flushFirst;
  logic [TAG_W-1:0] flushLast;
  logic [TAG_W:0] flushCount;
  logic redirectValid;
  logic redirectTaken;

  int checks = 0;
  int errs = 0;

  always #4 clk = ~clk;

  specwb_gate #(.TAG_W(TAG_W)) dut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input int cls, input int tag);
    issueValid = 1'b1;
    issueClass = 2'(cls);
    issueTag = TAG_W'(tag);
    tick();
    issueValid = 1'b0;
  endtask

  task automatic done(input int tag);
    doneValid = 1'b1;
    doneTag = TAG_W'(tag);
    tick();
    doneValid = 1'b0;
  endtask

  task automatic chkWb(input string req, input int exp);
    chk(wbEn == SLOTS'(exp), req, int'(wbEn), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    #1;
    // R1 reset state
    chkWb("R1", 0);
    chk(!flushValid && !redirectValid, "R1", int'(flushValid), 0);
    for (int c = 0; c < 4; c++) begin
      issueClass = 2'(c);
      #1;
      chk(issueReady, "R1", int'(issueReady), 1);
    end

    // R2 sweep over tags and non-branch classes
    for (int t = 0; t < SLOTS; t++) begin
      for (int c = 0; c < 3; c++) begin
        issue(c, t);
        done(t);
        chkWb("R2", 1 << t);
        tick();
        chkWb("R2", 0);
      end
    end

    // R10 completion on an empty tag
    done(5);
    chkWb("R10", 0);

    // speculative scenarios: n speculative issues, correct or mispredicted
    for (int n = 1; n <= 4; n++) begin
      for (int m = 0; m < 2; m++) begin
        int expMask;
        issue(0, 0);
        issue(3, 1);
        issueValid = 1'b0;
        issueClass = 2'd3;
        #1;
        chk(!issueReady, "R4", int'(issueReady), 0);
        issueClass = 2'd1;
        #1;
        chk(issueReady, "R4", int'(issueReady), 1);
        for (int k = 0; k < n; k++) issue(k % 3, 2 + k);
        expMask = 0;
        for (int k = 0; k < n - 1; k++) begin
          done(2 + k);
          chkWb("R3", 0);
          expMask |= 1 << (2 + k);
        end
        resolveValid = 1'b1;
        resolveMispredict = m[0];
        resolveTaken = n[0];
        #1;
        if (m == 1) begin
          chk(flushValid && redirectValid, "R6", int'(flushValid), 1);
          chk(redirectTaken == n[0], "R6", int'(redirectTaken), n % 2);
          chk(flushFirst == 2, "R6", int'(flushFirst), 2);
          chk(flushLast == TAG_W'(n + 1), "R6", int'(flushLast), n + 1);
          chk(flushCount == (TAG_W+1)'(n), "R6", int'(flushCount), n);
        end else begin
          chk(!flushValid && !redirectValid, "R5", int'(flushValid), 0);
        end
        tick();
        resolveValid = 1'b0;
        resolveMispredict = 1'b0;
        if (m == 0) begin
          chkWb("R5", expMask);
          tick();
          done(n + 1);
          chkWb("R5", 1 << (n + 1));
          tick();
        end else begin
          chkWb("R7", 0);
          done(n + 1);
          chkWb("R7", 0);
          done(2);
          chkWb("R7", 0);
        end
        done(0);
        chkWb("R7", 1);
        done(1);
        chkWb("R7", 2);
        tick();
        chkWb("R7", 0);
      end
    end

    // R8 issue in the resolve cycle is non-speculative
    issue(3, 0);
    issue(0, 1);
    resolveValid = 1'b1;
    resolveMispredict = 1'b1;
    issueValid = 1'b1;
    issueClass = 2'd0;
    issueTag = 3'd2;
    #1;
    chk(issueReady, "R8", int'(issueReady), 1);
    chk(flushCount == 1, "R8", int'(flushCount), 1);
    tick();
    resolveValid = 1'b0;
    resolveMispredict = 1'b0;
    issueValid = 1'b0;
    done(1);
    chkWb("R8", 0);
    done(2);
    chkWb("R8", 4);
    done(0);
    chkWb("R8", 1);
    tick();

    // R8 branch accepted in the resolve cycle opens a new window
    issue(3, 3);
    resolveValid = 1'b1;
    issueValid = 1'b1;
    issueClass = 2'd3;
    issueTag = 3'd4;
    #1;
    chk(issueReady, "R8", int'(issueReady), 1);
    tick();
    resolveValid = 1'b0;
    issueValid = 1'b0;
    #1;
    chk(!issueReady, "R8", int'(issueReady), 0);
    resolveValid = 1'b1;
    resolveMispredict = 1'b1;
    #1;
    chk(flushValid && flushCount == 0, "R6", int'(flushCount), 0);
    tick();
    resolveValid = 1'b0;
    resolveMispredict = 1'b0;
    done(3);
    chkWb("R2", 8);
    done(4);
    chkWb("R2", 16);
    tick();

    // R9 stray resolve
    resolveValid = 1'b1;
    resolveMispredict = 1'b1;
    #1;
    chk(!flushValid && !redirectValid, "R9", int'(flushValid), 0);
    tick();
    resolveValid = 1'b0;
    resolveMispredict = 1'b0;
    chkWb("R9", 0);
    issueClass = 2'd3;
    #1;
    chk(issueReady, "R9", int'(issueReady), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule